// File: doc/BRIEF.md
# Redundant-Path Multistage Switching Network

The block connects N = 2^N_LOG input ports to N output ports through N_LOG registered switching stages. Every stage holds N switches with three inputs and three outputs. A word at switch j of stage i moves to switch j of the next stage (straight), to switch (j + 2^i) mod N (up), or to switch (j − 2^i) mod N (down). The route of a word is a string of signed digits, one per stage, whose weighted sum equals (destination − source) mod N. Because a difference has many signed-digit forms, one source and destination pair can be joined over several distinct paths.

Each input port has a tag generator. It builds the digit string from the destination index. It can produce the plain binary form of the difference or a recoded form in which runs of ones become +1, zeros and −1. The generator can also be bypassed so that externally chosen tags (switch settings for a chosen permutation) steer the words. A word that carries an illegal digit code is discarded, and the error is reported against its source. When words compete for one switch, a fixed priority picks the winner. Each loser is discarded and raises a collision pulse against its source port. There is no buffering and no retry.

Top module: `gamma_net`

## Requirements
- R1: A word presented with its valid bit set in cycle c appears in cycle c+N_LOG on the output index equal to the route's end point. It carries its data unchanged, and out_src_o gives its input index. The latency is exactly N_LOG cycles, with one new word per port accepted every cycle.
- R2: With mode_i = 00, digit i of the tag is bit i of (dest − src) mod N. A digit is held in tag bits [2i+1:2i] and consumed by stage i. Code 00 keeps the switch index, 01 adds 2^i mod N, and 11 subtracts 2^i mod N.
- R3: With mode_i = 01, digit i is b(i−1) − b(i), where b is the binary difference and b(−1) = 0. The word still ends at its destination.
- R4: With mode_i = 10 or 11, the tag of port p is taken from in_tag_i[p*2*N_LOG +: 2*N_LOG]. The word ends at index (p + Σ digit_i·2^i) mod N.
- R5: A digit code 10 at digit i discards the word at stage i. tag_err_o[src] is high in cycle c+i+1, and the word never reaches an output.
- R6: When more than one word requests the same switch of a stage, the word that currently sits at the lowest switch index passes. Every other requester is discarded, and collide_o[src] is high in cycle c+i+1 for that stage i.
- R7: Asserting rst_ni low clears all outputs and every word in flight.
- R8: A port whose valid bit is low injects nothing: no output word and no flag, whatever its destination, tag or data.
- R9: mode_i is applied only to the words injected in the same cycle. Changing it every cycle does not alter words already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Tag source: 00 binary, 01 recoded, 1x external |
| in_valid_i | input | N | Per-port word valid |
| in_data_i | input | N*DATA_W | Per-port payload |
| in_dest_i | input | N*N_LOG | Per-port destination index |
| in_tag_i | input | N*2*N_LOG | Per-port external tag |
| out_valid_o | output | N | Per-output word valid |
| out_data_o | output | N*DATA_W | Per-output payload |
| out_src_o | output | N*N_LOG | Input index of the delivered word |
| collide_o | output | N | Per-source pulse: a word from this input lost arbitration |
| tag_err_o | output | N | Per-source pulse: a word from this input had an illegal digit |

## Verification
A wrong switch grant or a wrong link offset in any stage sends a word to a wrong output index, or discards it. Either fault shows at out_valid_o exactly N_LOG cycles after injection. A mis-sourced or mistimed drop appears as a collide_o or tag_err_o pulse on the wrong source bit, or in the wrong cycle, one cycle after the stage concerned. The singleton sweep over every source and destination pair in both generated modes isolates single-path faults. The permutation, shift and many-to-one patterns expose priority and flag faults.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam logic [1:0] DIG_ZERO = 2'b00;
  localparam logic [1:0] DIG_UP   = 2'b01;
  localparam logic [1:0] DIG_BAD  = 2'b10;
  localparam logic [1:0] DIG_DN   = 2'b11;

  localparam logic [1:0] MODE_BIN    = 2'b00;
  localparam logic [1:0] MODE_RECODE = 2'b01;
endpackage

// File: rtl/gamma_tag_gen.sv
module gamma_tag_gen import gamma_pkg::*; #(
  parameter int unsigned N_LOG = 3,
  parameter int unsigned SRC   = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 valid_i,
  input  logic [N_LOG-1:0]     dest_i,
  input  logic [2*N_LOG-1:0]   ext_tag_i,
  output logic [2*N_LOG-1:0]   tag_o
);
  localparam int unsigned TAG_W = 2 * N_LOG;

  logic [N_LOG-1:0] diff;
  logic [N_LOG:0]   prev_bit;  // prev_bit[i] = diff[i-1], prev_bit[0] = 0

  assign diff     = dest_i - N_LOG'(SRC);
  assign prev_bit = {diff, 1'b0};

  always_comb begin
    tag_o = '0;
    for (int i = 0; i < N_LOG; i++) begin
      if (mode_i == MODE_BIN) begin
        tag_o[2*i +: 2] = diff[i] ? DIG_UP : DIG_ZERO;
      end else if (mode_i == MODE_RECODE) begin
        unique case ({prev_bit[i], diff[i]})
          2'b10:   tag_o[2*i +: 2] = DIG_UP;
          2'b01:   tag_o[2*i +: 2] = DIG_DN;
          default: tag_o[2*i +: 2] = DIG_ZERO;
        endcase
      end else begin
        tag_o[2*i +: 2] = ext_tag_i[2*i +: 2];
      end
    end
  end

  function automatic logic [N_LOG-1:0] tag_offset(input logic [TAG_W-1:0] t);
    logic [N_LOG-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_LOG; i++) begin
      if (t[2*i +: 2] == DIG_UP) acc = acc + N_LOG'(1 << i);
      if (t[2*i +: 2] == DIG_DN) acc = acc - N_LOG'(1 << i);
    end
    return acc;
  endfunction

  // R2, R3: generated digits sum to the address difference
  a_r3_tag_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i[1]) |-> (tag_offset(tag_o) == dest_i - N_LOG'(SRC)));
endmodule

// File: rtl/gamma_switch.sv
module gamma_switch #(
  parameter int unsigned WORD_W = 14,
  parameter int unsigned IDX_S  = 0,
  parameter int unsigned IDX_U  = 0,
  parameter int unsigned IDX_D  = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             req_i,   // [0] straight, [1] from below, [2] from above
  input  logic [2:0][WORD_W-1:0] cand_i,
  output logic [2:0]             gnt_o,
  output logic                   valid_o,
  output logic [WORD_W-1:0]      word_o
);
  localparam bit U_LT_S = IDX_U < IDX_S;
  localparam bit D_LT_S = IDX_D < IDX_S;
  localparam bit D_LT_U = IDX_D < IDX_U;

  always_comb begin
    gnt_o[0] = req_i[0] && !(req_i[1] && U_LT_S) && !(req_i[2] && D_LT_S);
    gnt_o[1] = req_i[1] && !(req_i[0] && !U_LT_S) && !(req_i[2] && D_LT_U);
    gnt_o[2] = req_i[2] && !(req_i[0] && !D_LT_S) && !(req_i[1] && !D_LT_U);
  end

  logic [WORD_W-1:0] word_d;
  always_comb begin
    word_d = '0;
    for (int l = 0; l < 3; l++) if (gnt_o[l]) word_d = cand_i[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= |gnt_o;
      word_o  <= word_d;
    end
  end

  // R6: at most one word passes a switch per cycle
  a_r6_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6: any request produces a grant
  a_r6_no_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> valid_o);
endmodule

// File: rtl/gamma_stage.sv
module gamma_stage import gamma_pkg::*; #(
  parameter int unsigned N_LOG  = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STG    = 0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [(1<<N_LOG)-1:0]             valid_i,
  input  logic [3*N_LOG+DATA_W-1:0]         word_i [1<<N_LOG],
  output logic [(1<<N_LOG)-1:0]             valid_o,
  output logic [3*N_LOG+DATA_W-1:0]         word_o [1<<N_LOG],
  output logic [(1<<N_LOG)-1:0]             col_o,
  output logic [(1<<N_LOG)-1:0]             err_o
);
  localparam int unsigned N       = 1 << N_LOG;
  localparam int unsigned TAG_W   = 2 * N_LOG;
  localparam int unsigned WORD_W  = N_LOG + TAG_W + DATA_W;
  localparam int unsigned OFS     = 1 << STG;
  localparam int unsigned SRC_LSB = TAG_W + DATA_W;
  localparam int unsigned DIG_LSB = DATA_W + 2 * STG;

  logic [1:0]       dig [N];
  logic [N_LOG-1:0] src [N];
  logic [N-1:0]     go_s, go_u, go_d, bad, won;
  logic [N-1:0]     gnt_s, gnt_u, gnt_d;

  for (genvar j = 0; j < N; j++) begin : g_req
    assign dig[j]  = word_i[j][DIG_LSB +: 2];
    assign src[j]  = word_i[j][SRC_LSB +: N_LOG];
    assign go_s[j] = valid_i[j] && (dig[j] == DIG_ZERO);
    assign go_u[j] = valid_i[j] && (dig[j] == DIG_UP);
    assign go_d[j] = valid_i[j] && (dig[j] == DIG_DN);
    assign bad[j]  = valid_i[j] && (dig[j] == DIG_BAD);
  end

  for (genvar k = 0; k < N; k++) begin : g_sw
    localparam int unsigned KU = (k + N - OFS) % N;  // word arriving here moves up
    localparam int unsigned KD = (k + OFS) % N;      // word arriving here moves down
    logic [2:0] g;

    gamma_switch #(
      .WORD_W (WORD_W),
      .IDX_S  (k),
      .IDX_U  (KU),
      .IDX_D  (KD)
    ) u_sw (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   ({go_d[KD], go_u[KU], go_s[k]}),
      .cand_i  ({word_i[KD], word_i[KU], word_i[k]}),
      .gnt_o   (g),
      .valid_o (valid_o[k]),
      .word_o  (word_o[k])
    );

    assign gnt_s[k] = g[0];
    assign gnt_u[k] = g[1];
    assign gnt_d[k] = g[2];
    // word at k lands on k (straight), KD (up) or KU (down)
    assign won[k] = (go_s[k] && gnt_s[k]) || (go_u[k] && gnt_u[KD]) || (go_d[k] && gnt_d[KU]);

    // R1: a word only ever arrives over one of the three links
    a_r1_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o[k] |-> $past(valid_i[k] || valid_i[KU] || valid_i[KD]));
  end

  always_comb begin
    col_o = '0;
    err_o = '0;
    for (int j = 0; j < N; j++) begin
      if ((go_s[j] || go_u[j] || go_d[j]) && !won[j]) col_o[src[j]] = 1'b1;
      if (bad[j]) err_o[src[j]] = 1'b1;
    end
  end

  // R6: winners are exactly the words registered by the next stage
  a_r6_conserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(valid_o) == $past($countones(won))));
  // R5: an illegal digit never wins a switch
  a_r5_bad_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad & won) == '0);
endmodule

// File: rtl/gamma_net.sv
module gamma_net import gamma_pkg::*; #(
  parameter int unsigned N_LOG  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [1:0]                       mode_i,
  input  logic [(1<<N_LOG)-1:0]            in_valid_i,
  input  logic [(1<<N_LOG)*DATA_W-1:0]     in_data_i,
  input  logic [(1<<N_LOG)*N_LOG-1:0]      in_dest_i,
  input  logic [(1<<N_LOG)*2*N_LOG-1:0]    in_tag_i,
  output logic [(1<<N_LOG)-1:0]            out_valid_o,
  output logic [(1<<N_LOG)*DATA_W-1:0]     out_data_o,
  output logic [(1<<N_LOG)*N_LOG-1:0]      out_src_o,
  output logic [(1<<N_LOG)-1:0]            collide_o,
  output logic [(1<<N_LOG)-1:0]            tag_err_o
);
  localparam int unsigned N       = 1 << N_LOG;
  localparam int unsigned TAG_W   = 2 * N_LOG;
  localparam int unsigned WORD_W  = N_LOG + TAG_W + DATA_W;
  localparam int unsigned SRC_LSB = TAG_W + DATA_W;

  logic [N-1:0]        st_valid [N_LOG+1];
  logic [WORD_W-1:0]   st_word  [N_LOG+1][N];
  logic [N-1:0]        st_col   [N_LOG];
  logic [N-1:0]        st_err   [N_LOG];
  logic [N-1:0]        col_any, err_any, col_q, err_q;

  assign st_valid[0] = in_valid_i;

  for (genvar p = 0; p < N; p++) begin : g_port
    logic [TAG_W-1:0] tag;
    gamma_tag_gen #(
      .N_LOG (N_LOG),
      .SRC   (p)
    ) u_tag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_i),
      .valid_i   (in_valid_i[p]),
      .dest_i    (in_dest_i[p*N_LOG +: N_LOG]),
      .ext_tag_i (in_tag_i[p*TAG_W +: TAG_W]),
      .tag_o     (tag)
    );
    assign st_word[0][p] = {N_LOG'(p), tag, in_data_i[p*DATA_W +: DATA_W]};
  end

  for (genvar g = 0; g < N_LOG; g++) begin : g_stg
    gamma_stage #(
      .N_LOG  (N_LOG),
      .DATA_W (DATA_W),
      .STG    (g)
    ) u_stg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (st_valid[g]),
      .word_i  (st_word[g]),
      .valid_o (st_valid[g+1]),
      .word_o  (st_word[g+1]),
      .col_o   (st_col[g]),
      .err_o   (st_err[g])
    );
  end

  always_comb begin
    col_any = '0;
    err_any = '0;
    for (int g = 0; g < N_LOG; g++) begin
      col_any = col_any | st_col[g];
      err_any = err_any | st_err[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      err_q <= '0;
    end else begin
      col_q <= col_any;
      err_q <= err_any;
    end
  end

  assign out_valid_o = st_valid[N_LOG];
  assign collide_o   = col_q;
  assign tag_err_o   = err_q;

  function automatic logic [N_LOG-1:0] tag_offset(input logic [TAG_W-1:0] t);
    logic [N_LOG-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_LOG; i++) begin
      if (t[2*i +: 2] == DIG_UP) acc = acc + N_LOG'(1 << i);
      if (t[2*i +: 2] == DIG_DN) acc = acc - N_LOG'(1 << i);
    end
    return acc;
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_out
    assign out_data_o[k*DATA_W +: DATA_W] = st_word[N_LOG][k][DATA_W-1:0];
    assign out_src_o[k*N_LOG +: N_LOG]    = st_word[N_LOG][k][SRC_LSB +: N_LOG];

    // R1: delivered word sits at source plus its route offset
    a_r1_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[k] |-> (tag_offset(st_word[N_LOG][k][DATA_W +: TAG_W]) ==
                          N_LOG'(k) - st_word[N_LOG][k][SRC_LSB +: N_LOG]));
  end
endmodule

// File: tb/gamma_net_tb_top.sv
module gamma_net_tb_top;
  localparam int N_LOG = 3;
  localparam int N     = 1 << N_LOG;
  localparam int DW    = 8;
  localparam int TW    = 2 * N_LOG;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC  = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = '0;
  logic [N-1:0]      in_valid = '0;
  logic [N*DW-1:0]   in_data = '0;
  logic [N*N_LOG-1:0] in_dest = '0;
  logic [N*TW-1:0]   in_tag = '0;
  logic [N-1:0]      out_valid, collide, tag_err;
  logic [N*DW-1:0]   out_data;
  logic [N*N_LOG-1:0] out_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_net #(.N_LOG(N_LOG), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_dest_i(in_dest), .in_tag_i(in_tag),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_src_o(out_src),
    .collide_o(collide), .tag_err_o(tag_err)
  );

  // stimulus plan
  logic [N-1:0]    drv_valid [MAXC];
  int              drv_dest  [MAXC][N];
  logic [TW-1:0]   drv_tag   [MAXC][N];
  logic [DW-1:0]   drv_data  [MAXC][N];
  logic [1:0]      drv_mode  [MAXC];
  // expectations
  logic [N-1:0]    exp_vld [MAXC];
  logic [DW-1:0]   exp_dat [MAXC][N];
  int              exp_src [MAXC][N];
  logic [N-1:0]    exp_col [MAXC];
  logic [N-1:0]    exp_err [MAXC];
  string           exp_lbl [MAXC];

  int            b_dst [N];
  logic [TW-1:0] b_tag [N];
  int n_chk = 0, n_fail = 0;
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // arithmetic model: signed digits, stage offsets 2^i, lowest current index wins
  task automatic plan(input int c, input logic [N-1:0] v, input logic [1:0] md, input string lbl);
    int pos [N]; bit alive [N]; int dg [N][N_LOG]; bit bd [N][N_LOG]; int tgt [N]; bit lose [N];
    drv_valid[c] = v; drv_mode[c] = md;
    for (int s = 0; s < N; s++) begin
      int diff = (b_dst[s] - s + N) % N;
      drv_dest[c][s] = b_dst[s]; drv_tag[c][s] = b_tag[s];
      drv_data[c][s] = DW'(c * 37 + s * 11 + 5);
      pos[s] = s; alive[s] = v[s];
      for (int i = 0; i < N_LOG; i++) begin
        bd[s][i] = 0;
        if (md == 2'b00) dg[s][i] = (diff >> i) & 1;
        else if (md == 2'b01) dg[s][i] = (i == 0 ? 0 : ((diff >> (i-1)) & 1)) - ((diff >> i) & 1);
        else begin
          case (b_tag[s][2*i +: 2])
            2'b00: dg[s][i] = 0;
            2'b01: dg[s][i] = 1;
            2'b11: dg[s][i] = -1;
            default: begin dg[s][i] = 0; bd[s][i] = 1; end
          endcase
        end
      end
    end
    for (int i = 0; i < N_LOG; i++) begin
      for (int s = 0; s < N; s++) if (alive[s] && bd[s][i]) begin
        alive[s] = 0; exp_err[c+i+1][s] = 1'b1;
      end
      for (int s = 0; s < N; s++) tgt[s] = ((pos[s] + dg[s][i] * (1 << i)) % N + N) % N;
      for (int s = 0; s < N; s++) begin
        lose[s] = 0;
        for (int r = 0; r < N; r++)
          if (alive[s] && alive[r] && r != s && tgt[r] == tgt[s] && pos[r] < pos[s]) lose[s] = 1;
      end
      for (int s = 0; s < N; s++) begin
        if (lose[s]) begin alive[s] = 0; exp_col[c+i+1][s] = 1'b1; end
        pos[s] = tgt[s];
      end
    end
    for (int s = 0; s < N; s++) if (alive[s]) begin
      exp_vld[c+N_LOG][pos[s]] = 1'b1;
      exp_dat[c+N_LOG][pos[s]] = drv_data[c][s];
      exp_src[c+N_LOG][pos[s]] = s;
    end
    exp_lbl[c+N_LOG] = lbl;
  endtask

  task automatic rand_perm();
    for (int i = 0; i < N; i++) b_dst[i] = i;
    for (int i = N-1; i > 0; i--) begin
      int j = int'(rnd() % (i + 1));
      int t = b_dst[i]; b_dst[i] = b_dst[j]; b_dst[j] = t;
    end
  endtask

  task automatic check_cycle(input int t);
    for (int k = 0; k < N; k++) begin
      check(out_valid[k] == exp_vld[t][k], exp_lbl[t], $sformatf("cyc %0d out %0d valid", t, k),
            out_valid[k], exp_vld[t][k]);
      if (exp_vld[t][k] && out_valid[k]) begin
        check(out_data[k*DW +: DW] == exp_dat[t][k], exp_lbl[t], $sformatf("cyc %0d out %0d data", t, k),
              out_data[k*DW +: DW], exp_dat[t][k]);
        check(int'(out_src[k*N_LOG +: N_LOG]) == exp_src[t][k], exp_lbl[t],
              $sformatf("cyc %0d out %0d src", t, k), out_src[k*N_LOG +: N_LOG], exp_src[t][k]);
      end
    end
    check(collide == exp_col[t], "R6", $sformatf("cyc %0d collide", t), collide, exp_col[t]);
    check(tag_err == exp_err[t], "R5", $sformatf("cyc %0d tag_err", t), tag_err, exp_err[t]);
  endtask

  task automatic drive(input int t);
    mode = drv_mode[t]; in_valid = drv_valid[t];
    for (int s = 0; s < N; s++) begin
      in_dest[s*N_LOG +: N_LOG] = N_LOG'(drv_dest[t][s]);
      in_tag[s*TW +: TW]        = drv_tag[t][s];
      in_data[s*DW +: DW]       = drv_data[t][s];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c;
    int total;
    for (int t = 0; t < MAXC; t++) begin
      drv_valid[t] = '0; drv_mode[t] = '0; exp_vld[t] = '0; exp_col[t] = '0; exp_err[t] = '0;
      exp_lbl[t] = "R1";
      for (int s = 0; s < N; s++) begin
        drv_dest[t][s] = 0; drv_tag[t][s] = '0; drv_data[t][s] = '0;
        exp_dat[t][s] = '0; exp_src[t][s] = 0;
      end
    end
    for (int s = 0; s < N; s++) b_tag[s] = '0;
    c = 0;
    // R2, R3: every single source/destination pair in both generated modes
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < N; s++)
        for (int d = 0; d < N; d++) begin
          for (int q = 0; q < N; q++) b_dst[q] = 0;
          b_dst[s] = d;
          plan(c, N'(1) << s, 2'(md), md == 0 ? "R2" : "R3");
          c++;
        end
    // R1: identity, then uniform shifts (no contention)
    for (int md = 0; md < 2; md++)
      for (int sh = 0; sh < N; sh++) begin
        for (int s = 0; s < N; s++) b_dst[s] = (s + sh) % N;
        plan(c, '1, 2'(md), sh == 0 ? "R1" : (md == 0 ? "R2" : "R3"));
        c++;
      end
    // R9: random permutations, mode flips every cycle
    for (int r = 0; r < 40; r++) begin
      rand_perm();
      plan(c, '1, 2'(r % 2), "R9");
      c++;
    end
    // R6: many-to-one traffic with partial valid
    for (int r = 0; r < 40; r++) begin
      for (int s = 0; s < N; s++) b_dst[s] = int'(rnd() % 3);
      plan(c, N'(rnd()), 2'(rnd() % 2), "R6");
      c++;
    end
    // R6: directed stage-0 clash: port 0 straight, port 1 down by one
    for (int s = 0; s < N; s++) b_tag[s] = '0;
    b_tag[1] = TW'(2'b11);
    plan(c, N'(3), 2'b10, "R6");
    c++;
    // R4, R5: external tags, illegal digits included
    for (int r = 0; r < 40; r++) begin
      for (int s = 0; s < N; s++) b_tag[s] = TW'(rnd());
      plan(c, N'(rnd()) | N'(1), 2'(2 + (r % 2)), "R4");
      c++;
    end
    // R8: invalid words carrying illegal tags and random destinations
    for (int r = 0; r < 10; r++) begin
      for (int s = 0; s < N; s++) begin b_tag[s] = TW'(rnd()) | TW'(2'b10); b_dst[s] = int'(rnd() % N); end
      plan(c, '0, 2'(rnd()), "R8");
      c++;
    end
    total = c + N_LOG + 3;

    // R7: reset state
    repeat (3) @(negedge clk);
    check(out_valid == '0 && collide == '0 && tag_err == '0, "R7", "reset outputs",
          {out_valid, collide, tag_err}, 0);
    rst_n = 1'b1;

    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      check_cycle(t);
      drive(t);
    end

    // R7: reset while words are in flight
    @(negedge clk);
    mode = 2'b00; in_valid = '1;
    for (int s = 0; s < N; s++) in_dest[s*N_LOG +: N_LOG] = N_LOG'(s);
    @(negedge clk);
    in_valid = '0; rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == '0 && collide == '0, "R7", "outputs in reset", {out_valid, collide}, 0);
    rst_n = 1'b1;
    for (int t = 0; t < N_LOG + 1; t++) begin
      @(negedge clk);
      check(out_valid == '0, "R7", "flushed word after reset", out_valid, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule